// File: doc/BRIEF.md
# Display RAM Host Access Controller

This block connects a microcontroller-style parallel bus to an on-chip display data RAM. The host reaches it through a data/command select, two strobe pins and an 8-bit data bus. With the select low, a write is a command and a read returns a status byte. With the select high, reads and writes move pixel bytes between the bus and the RAM. A mode input chooses how the two strobe pins are read: either as a direction level plus an enable pulse, or as separate active-low write and read strobes.

The block samples the strobes in its own clock domain through two-flop synchronizers. It acts on each access when the strobe is released, so the host must hold data and select steady until then. A page register and a column pointer form the RAM address. Three command codes load them, and they keep their values until changed. Every data access moves the column pointer on by one, and the pointer returns to zero after the last column. Reads go through a prefetch buffer that is one access behind, so the first read after an address change returns stale data.

Top module: `dram_host_ctrl`

## Requirements
- R1: A read with the select low returns the status byte: bit 7 is the busy flag input, bit 6 the display-on flag input, bit 5 the resetting flag input, and bits 4..0 are zero.
- R2: The command byte 1011_pppp loads the page register with pppp if pppp is below PAGES. Otherwise the page is unchanged. Any command byte that matches none of the three codes changes nothing.
- R3: The command 0001_hhhh replaces the upper nibble of the column pointer, and 0000_llll replaces the lower nibble. A result above COLS-1 (95) is loaded as 95.
- R4: A data write stores the bus byte at the current page and column. It then advances the column pointer by one.
- R5: A data read drives the prefetch buffer on data_o. It then loads the buffer from the current page and column and advances the column pointer. The first read after an address change therefore returns stale data, and each later read returns the byte at the column addressed by the read before it.
- R6: An access at column 95 uses column 95, and the pointer then becomes 0.
- R7: With mode_8080_i low, e_rdn_i high marks an access and rw_wrn_i high makes it a read. The access takes effect after e_rdn_i falls, and at most one access is taken per strobe.
- R8: With mode_8080_i high, rw_wrn_i low marks a write and e_rdn_i low marks a read. The access takes effect after the strobe rises.
- R9: Status reads do not move the page or the column. The page and column stay set across any number of data accesses, so they need no reload.
- R10: Only data reads load the prefetch buffer. Writes and commands leave it as it was.
- R11: After reset the page and column are 0 and the prefetch buffer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_8080_i | input | 1 | Strobe style: 0 = direction + enable, 1 = separate write/read strobes |
| dc_i | input | 1 | Data/command select: 1 = RAM data, 0 = command/status |
| rw_wrn_i | input | 1 | Direction level (1 = read) or active-low write strobe |
| e_rdn_i | input | 1 | Enable pulse (active high) or active-low read strobe |
| data_i | input | 8 | Bus data from host |
| data_o | output | 8 | Read data: prefetch buffer when dc_i=1, status byte when dc_i=0 |
| busy_i | input | 1 | Busy flag for status bit 7 |
| disp_on_i | input | 1 | Display-on flag for status bit 6 |
| in_reset_i | input | 1 | Resetting flag for status bit 5 |

## Verification
Two things happen on one access event: the access at the last column and the pointer wrap. The same event also stores or fetches the RAM byte and steps the address. The bench clamps the column to 95 and then writes or reads there. Through later reads it checks that the byte went to column 95 and that the next access lands on column 0. It also checks that the prefetch buffer captured the column-95 byte and not the byte at the wrapped address, while random traffic often crosses the wrap in both strobe modes.

// File: rtl/dram_host_pkg.sv
package dram_host_pkg;
  typedef struct packed {
    logic fire;
    logic rd;
    logic dc;
  } acc_ev_t;

  localparam logic [3:0] OP_PAGE   = 4'b1011;
  localparam logic [3:0] OP_COL_HI = 4'b0001;
  localparam logic [3:0] OP_COL_LO = 4'b0000;
endpackage

// File: rtl/bus_sync.sv
module bus_sync #(
  parameter int W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
      end else begin
        s1 <= d_i[i];
        s2 <= s1;
      end
    end
    assign q_o[i] = s2;
  end
endmodule

// File: rtl/access_decode.sv
module access_decode
  import dram_host_pkg::*;
#(
  parameter int WARM = 3
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    mode_8080_i,
  input  logic    dc_s_i,
  input  logic    a_s_i,
  input  logic    b_s_i,
  output acc_ev_t ev_o
);
  localparam int WW = $clog2(WARM + 1);

  logic [WW-1:0] warm_q;
  logic          primed, act, rd, act_q, rd_q, dc_q;

  // strobe meaning depends on the mode
  always_comb begin
    if (mode_8080_i) begin
      act = !a_s_i || !b_s_i;
      rd  = !b_s_i;
    end else begin
      act = b_s_i;
      rd  = a_s_i;
    end
  end

  // hold off until synchronizers carry real pin levels
  assign primed = (warm_q == WW'(WARM));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      warm_q <= '0;
      act_q  <= 1'b0;
      rd_q   <= 1'b0;
      dc_q   <= 1'b0;
    end else begin
      if (!primed) warm_q <= warm_q + 1'b1;
      act_q <= primed && act;
      if (primed && act) begin
        rd_q <= rd;
        dc_q <= dc_s_i;
      end
    end
  end

  assign ev_o.fire = act_q && !(primed && act);
  assign ev_o.rd   = rd_q;
  assign ev_o.dc   = dc_q;
endmodule

// File: rtl/addr_ptr.sv
module addr_ptr
  import dram_host_pkg::*;
#(
  parameter int PAGES = 8,
  parameter int COLS  = 96,
  localparam int PW = $clog2(PAGES),
  localparam int CW = $clog2(COLS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  acc_ev_t       ev_i,
  input  logic [7:0]    cmd_i,
  output logic [PW-1:0] page_o,
  output logic [CW-1:0] col_o
);
  localparam logic [7:0] COL_MAX = 8'(COLS - 1);

  logic [PW-1:0] page_q;
  logic [CW-1:0] col_q;
  logic [7:0]    col_ext, cand_hi, cand_lo;
  logic          is_cmd, is_data;

  assign is_cmd  = ev_i.fire && !ev_i.rd && !ev_i.dc;
  assign is_data = ev_i.fire && ev_i.dc;
  assign col_ext = 8'(col_q);
  assign cand_hi = {cmd_i[3:0], col_ext[3:0]};
  assign cand_lo = {col_ext[7:4], cmd_i[3:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_q <= '0;
      col_q  <= '0;
    end else if (is_cmd) begin
      unique case (cmd_i[7:4])
        OP_PAGE:   if (32'(cmd_i[3:0]) < PAGES) page_q <= PW'(cmd_i[3:0]);
        OP_COL_HI: col_q <= (cand_hi > COL_MAX) ? CW'(COL_MAX) : CW'(cand_hi);
        OP_COL_LO: col_q <= (cand_lo > COL_MAX) ? CW'(COL_MAX) : CW'(cand_lo);
        default: ;
      endcase
    end else if (is_data) begin
      col_q <= (col_q == CW'(COLS - 1)) ? '0 : col_q + 1'b1;
    end
  end

  assign page_o = page_q;
  assign col_o  = col_q;
endmodule

// File: rtl/dram_host_ctrl.sv
module dram_host_ctrl
  import dram_host_pkg::*;
#(
  parameter int PAGES = 8,
  parameter int COLS  = 96,
  localparam int PW    = $clog2(PAGES),
  localparam int CW    = $clog2(COLS),
  localparam int DEPTH = PAGES * COLS,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       mode_8080_i,
  input  logic       dc_i,
  input  logic       rw_wrn_i,
  input  logic       e_rdn_i,
  input  logic [7:0] data_i,
  output logic [7:0] data_o,
  input  logic       busy_i,
  input  logic       disp_on_i,
  input  logic       in_reset_i
);
  logic [2:0]    pins_s;
  acc_ev_t       ev;
  logic [PW-1:0] page;
  logic [CW-1:0] col;
  logic [AW-1:0] idx;
  logic [7:0]    rd_buf;
  logic [7:0]    mem [DEPTH];
  logic          wr_en, rd_en;

  bus_sync #(.W(3)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({dc_i, rw_wrn_i, e_rdn_i}),
    .q_o   (pins_s)
  );

  access_decode u_dec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_8080_i(mode_8080_i),
    .dc_s_i     (pins_s[2]),
    .a_s_i      (pins_s[1]),
    .b_s_i      (pins_s[0]),
    .ev_o       (ev)
  );

  // data_i is held by the host past the strobe release
  addr_ptr #(.PAGES(PAGES), .COLS(COLS)) u_ptr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ev_i  (ev),
    .cmd_i (data_i),
    .page_o(page),
    .col_o (col)
  );

  assign idx   = AW'(page) * AW'(COLS) + AW'(col);
  assign wr_en = ev.fire && ev.dc && !ev.rd;
  assign rd_en = ev.fire && ev.dc && ev.rd;

  always_ff @(posedge clk_i) begin
    if (wr_en) mem[idx] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    rd_buf <= '0;
    else if (rd_en) rd_buf <= mem[idx];
  end

  assign data_o = dc_i ? rd_buf : {busy_i, disp_on_i, in_reset_i, 5'b0};
endmodule

// File: rtl/dram_host_chk.sv
module dram_host_chk #(
  parameter int PAGES = 8,
  parameter int COLS  = 96,
  localparam int PW = $clog2(PAGES),
  localparam int CW = $clog2(COLS)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          fire,
  input logic          rd,
  input logic          dc,
  input logic [PW-1:0] page,
  input logic [CW-1:0] col,
  input logic [7:0]    rd_buf
);
  // R6
  col_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(col) < COLS);

  // R2
  page_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(page) < PAGES);

  // R6
  wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && dc && 32'(col) == COLS - 1) |=> (col == '0));

  // R4
  incr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && dc && 32'(col) != COLS - 1) |=> (col == CW'($past(col) + 1'b1)));

  // R9
  status_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && rd && !dc) |=> ($stable(col) && $stable(page)));

  // R10
  buf_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && !(rd && dc)) |=> $stable(rd_buf));

  // R7
  single_fire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> !fire);
endmodule

bind dram_host_ctrl dram_host_chk #(.PAGES(PAGES), .COLS(COLS)) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .fire  (ev.fire),
  .rd    (ev.rd),
  .dc    (ev.dc),
  .page  (page),
  .col   (col),
  .rd_buf(rd_buf)
);

// File: tb/sim_dram_host_ctrl.sv
module sim_dram_host_ctrl;
  localparam int PAGES = 8;
  localparam int COLS  = 96;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic mode_8080 = 1'b0, dc = 1'b0, rw_wrn = 1'b0, e_rdn = 1'b0;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic busy = 1'b0, disp_on = 1'b0, in_rst = 1'b0;

  int errors = 0, checks = 0;
  bit done = 1'b0;

  logic [7:0] m_mem [PAGES][COLS];
  int m_page = 0, m_col = 0;
  logic [7:0] m_buf = '0;

  always #4 clk = ~clk;

  dram_host_ctrl #(.PAGES(PAGES), .COLS(COLS)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .mode_8080_i(mode_8080), .dc_i(dc),
    .rw_wrn_i(rw_wrn), .e_rdn_i(e_rdn), .data_i(din), .data_o(dout),
    .busy_i(busy), .disp_on_i(disp_on), .in_reset_i(in_rst)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  function automatic int clamp_col(input int v);
    return (v > COLS - 1) ? COLS - 1 : v;
  endfunction

  function automatic void model_cmd(input logic [7:0] d);
    case (d[7:4])
      4'b1011: if (int'(d[3:0]) < PAGES) m_page = int'(d[3:0]);
      4'b0001: m_col = clamp_col(int'(d[3:0]) * 16 + (m_col % 16));
      4'b0000: m_col = clamp_col((m_col / 16) * 16 + int'(d[3:0]));
      default: ;
    endcase
  endfunction

  function automatic void step_col();
    m_col = (m_col == COLS - 1) ? 0 : m_col + 1;
  endfunction

  task automatic idle_pins(input logic m);
    rw_wrn = m;
    e_rdn  = m;
  endtask

  task automatic do_reset(input logic m);
    @(negedge clk);
    rst_ni = 1'b0;
    mode_8080 = m;
    idle_pins(m);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (6) @(negedge clk);
    m_page = 0; m_col = 0; m_buf = '0;
  endtask

  task automatic bus_op(input logic rd, input logic d_c, input logic [7:0] wd,
                        output logic [7:0] rv);
    @(negedge clk);
    dc = d_c;
    din = wd;
    if (!mode_8080) begin
      rw_wrn = rd;
      repeat (3) @(negedge clk);
      e_rdn = 1'b1;
    end else if (rd) e_rdn = 1'b0;
    else rw_wrn = 1'b0;
    repeat (4) @(negedge clk);
    rv = dout;
    if (!mode_8080) e_rdn = 1'b0;
    else idle_pins(1'b1);
    repeat (7) @(negedge clk);
  endtask

  task automatic cmd(input logic [7:0] d);
    logic [7:0] rv;
    bus_op(1'b0, 1'b0, d, rv);
    model_cmd(d);
  endtask

  task automatic wr_data(input logic [7:0] d);
    logic [7:0] rv;
    bus_op(1'b0, 1'b1, d, rv);
    m_mem[m_page][m_col] = d;
    step_col();
  endtask

  task automatic rd_data(input string req, input bit chk);
    logic [7:0] rv;
    bus_op(1'b1, 1'b1, 8'h00, rv);
    if (chk) check(req, rv, m_buf);
    m_buf = m_mem[m_page][m_col];
    step_col();
  endtask

  task automatic rd_status(input string req);
    logic [7:0] rv;
    logic [7:0] exp;
    busy = 1'($urandom); disp_on = 1'($urandom); in_rst = 1'($urandom);
    exp = {busy, disp_on, in_rst, 5'b0};
    bus_op(1'b1, 1'b0, 8'h00, rv);
    check(req, rv, exp);
  endtask

  task automatic set_addr(input int p, input int c);
    cmd({4'b1011, 4'(p)});
    cmd({4'b0001, 4'(c / 16)});
    cmd({4'b0000, 4'(c % 16)});
  endtask

  task automatic random_ops(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      int k;
      k = int'($urandom_range(0, 9));
      case (k)
        0: cmd({4'b1011, 4'($urandom)});
        1: cmd({4'b0001, 4'($urandom)});
        2: cmd({4'b0000, 4'($urandom)});
        3: cmd(8'($urandom));
        4, 5: wr_data(8'($urandom));
        6, 7, 8: rd_data({tag, " R5 random read"}, 1'b1);
        default: rd_status({tag, " R1 random status"});
      endcase
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] rv;
    void'($urandom(32'd4242));
    do_reset(1'b0);
    dc = 1'b1;
    @(negedge clk);
    check("R11 buffer after reset", dout, 8'h00);
    rd_data("R11 first read returns reset buffer", 1'b1);
    cmd(8'h00);

    // R4 fill every location, crossing the wrap per page
    for (int p = 0; p < PAGES; p++) begin
      set_addr(p, 0);
      for (int c = 0; c < COLS; c++) wr_data(8'((p * 37 + c * 5) ^ 8'h5a));
    end

    // R5 dummy read then sequential data
    set_addr(2, 10);
    rd_data("R5 dummy", 1'b0);
    for (int i = 0; i < 4; i++) rd_data("R5 sequential read", 1'b1);

    // R2 invalid page ignored
    set_addr(3, 20);
    cmd(8'b1011_1010);
    cmd(8'h7e);
    rd_data("R2 dummy", 1'b0);
    rd_data("R2 page kept after invalid page", 1'b1);
    check("R2 page model", 8'(m_page), 8'd3);

    // R3 clamp to 95, R6 wrap
    cmd(8'b0001_0111);
    check("R3 clamp model", 8'(m_col), 8'd95);
    rd_data("R3 dummy", 1'b0);
    rd_data("R3 R6 read at column 95", 1'b1);
    rd_data("R6 read after wrap at column 0", 1'b1);
    set_addr(5, 95);
    cmd(8'b0000_1111);
    wr_data(8'hc3);
    wr_data(8'h3c);
    set_addr(5, 95);
    rd_data("R6 dummy", 1'b0);
    rd_data("R6 write landed at column 95", 1'b1);
    rd_data("R6 write wrapped to column 0", 1'b1);

    // R10 writes leave the prefetch buffer
    set_addr(1, 40);
    rd_data("R10 dummy", 1'b0);
    wr_data(8'h99);
    cmd(8'h02);
    rd_data("R10 buffer kept across write and command", 1'b1);

    // R9 status reads keep the pointer
    set_addr(4, 50);
    rd_data("R9 dummy", 1'b0);
    rd_status("R1 status 6800");
    rd_status("R1 status 6800");
    rd_data("R9 read after status reads", 1'b1);
    rd_data("R9 pointer continues", 1'b1);

    random_ops(300, "R7 6800");

    // R8 write/read strobe style
    do_reset(1'b1);
    dc = 1'b1;
    @(negedge clk);
    check("R11 buffer after reset in 8080 mode", dout, 8'h00);
    set_addr(6, 90);
    for (int i = 0; i < 8; i++) wr_data(8'(8'hA0 + i));
    set_addr(6, 90);
    rd_data("R8 dummy", 1'b0);
    for (int i = 0; i < 8; i++) rd_data("R8 read across wrap", 1'b1);
    rd_status("R8 R1 status 8080");
    random_ops(300, "R8 8080");

    do_reset(1'b0);
    random_ops(150, "R7 6800 after mode change");

    bus_op(1'b1, 1'b1, 8'h00, rv);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule